// File: doc/BRIEF.md
# Outstanding Load Miss Tracker

This block keeps track of load misses that a non-blocking cache has sent to memory and not yet received back. Each tracking entry covers one whole memory line and records, word by word, which destination register is waiting for that word. A load miss to a line that has no entry claims a free entry and causes one line request to memory. A load miss to a line that already has an entry joins that entry and sends nothing new. In both cases the load leaves the pipeline at once.

Every architectural register has a full/empty bit. Accepting a load clears its destination bit. The decode stage asks the block whether either source operand of the instruction it holds is empty, and keeps that instruction back while the answer is yes. When a line comes back from memory, all of its waiting words go out on parallel write-back lanes in that cycle. The registers they target are marked full and the entry is released.

Line requests leave in the order the entries were claimed. Returns may arrive in any order and are matched by line address. A miss that cannot be taken this cycle is refused with a stall. Causes are: no free entry, the word already has a waiter, the destination is already pending, or the line is returning in that same cycle.

Top module: `mshr_file`

## Requirements
- R1: After reset every register is marked full, no line request is presented and no miss is stalled.
- R2: A miss to a line with no entry, while an entry is free, is accepted (missStall low) and that line is presented on memReqLine exactly once.
- R3: A miss to a line that already has an entry, for a word with no waiter, is accepted and adds no line request.
- R4: A miss to a word of a pending line that already has a waiting register is stalled and changes no state.
- R5: With all NUM_ENTRIES entries in use, a miss to a line without an entry is stalled.
- R6: One cycle after a miss is accepted, regFull of its destination register is 0.
- R7: decHold is high exactly when regFull is 0 for decSrcA or for decSrcB.
- R8: In a cycle with fillValid and a fillLine that matches an entry, lane k has wbValid[k] high for each waiting word k, with that word's register on wbDest[k] and fillData[k*WORD_W +: WORD_W] on wbData[k] (word 0 in the lowest bits). One cycle later those registers read full and the entry is free.
- R9: Line requests are presented in the order the entries were allocated; while memReqReady is low, memReqValid and memReqLine hold steady.
- R10: A miss whose destination register is already empty is stalled.
- R11: A miss to the line that is returning on fillLine in the same cycle is stalled.
- R12: A fill whose line matches no entry raises no wbValid and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A load miss is offered this cycle |
| missLine | input | LINE_W | Line address of the miss |
| missWord | input | log2(WORDS) | Word offset within the line |
| missDest | input | REG_W | Destination register of the load |
| missStall | output | 1 | The offered miss is refused this cycle |
| decSrcA | input | REG_W | First source register of the instruction in decode |
| decSrcB | input | REG_W | Second source register of the instruction in decode |
| decHold | output | 1 | A source register is still empty |
| memReqValid | output | 1 | A line request is presented |
| memReqLine | output | LINE_W | Line address of the presented request |
| memReqReady | input | 1 | Memory takes the request this cycle |
| fillValid | input | 1 | A line is returning from memory |
| fillLine | input | LINE_W | Line address of the returning data |
| fillData | input | WORDS*WORD_W | Returned line, word 0 in the lowest bits |
| wbValid | output | WORDS | Per-word write-back strobes |
| wbDest | output | WORDS*REG_W | Per-word target registers |
| wbData | output | WORDS*WORD_W | Per-word write data |
| regFull | output | 2**REG_W | Full/empty bit of every register, 1 = full |

## Verification
The bench first runs directed sequences. They cover a miss that claims an entry, a miss that joins that entry, and a word conflict on it, which separates allocation from merging from refusal. Entries are then filled until none is free, with memory held back, to show both the stall and the in-order release of requests. After that, lines are returned out of order, including a line nobody waits for and a line that returns in the same cycle as a miss to it; these separate a correct match from a stale or missing one. A long pseudo-random run follows. It mixes merges, refusals, back-pressure and fills in any order of the issued lines, and compares the stall, request, write-back and full/empty outputs with the bench's own model in every cycle.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef struct packed {
    logic allocEn;
    logic mergeEn;
    logic fillEn;
  } mshrStrobes_t;
endpackage

// File: rtl/mshr_datapath.sv
module mshr_datapath
  import mshr_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int LINE_W      = 10,
  parameter int WORDS       = 4,
  parameter int WORD_W      = 16,
  parameter int REG_W       = 5,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int OFF_W      = $clog2(WORDS),
  localparam int NUM_REGS   = 1 << REG_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mshrStrobes_t            strobes,
  input  logic [NUM_ENTRIES-1:0]  allocSel,
  input  logic [IDX_W-1:0]        headIdx,
  input  logic [LINE_W-1:0]       missLine,
  input  logic [OFF_W-1:0]        missWord,
  input  logic [REG_W-1:0]        missDest,
  input  logic [LINE_W-1:0]       fillLine,
  input  logic [WORDS*WORD_W-1:0] fillData,
  input  logic [REG_W-1:0]        decSrcA,
  input  logic [REG_W-1:0]        decSrcB,
  output logic [NUM_ENTRIES-1:0]  entryValid,
  output logic [NUM_ENTRIES-1:0]  missHit,
  output logic                    slotBusy,
  output logic                    destEmpty,
  output logic [LINE_W-1:0]       headLine,
  output logic                    decHold,
  output logic [WORDS-1:0]        wbValid,
  output logic [WORDS*REG_W-1:0]  wbDest,
  output logic [WORDS*WORD_W-1:0] wbData,
  output logic [NUM_REGS-1:0]     regFull
);
  logic [NUM_ENTRIES-1:0] entValid;
  logic [LINE_W-1:0]      entLine  [NUM_ENTRIES];
  logic [WORDS-1:0]       entWordV [NUM_ENTRIES];
  logic [REG_W-1:0]       entDest  [NUM_ENTRIES][WORDS];
  logic [NUM_REGS-1:0]    fullQ;
  logic [NUM_ENTRIES-1:0] fillHit;
  logic [NUM_REGS-1:0]    fullSet;
  logic [NUM_REGS-1:0]    fullClr;

  assign entryValid = entValid;
  assign regFull    = fullQ;
  assign headLine   = entLine[headIdx];
  assign destEmpty  = !fullQ[missDest];
  assign decHold    = !fullQ[decSrcA] || !fullQ[decSrcB];

  always_comb begin
    slotBusy = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      missHit[i] = entValid[i] && (entLine[i] == missLine);
      fillHit[i] = strobes.fillEn && entValid[i] && (entLine[i] == fillLine);
      if (missHit[i] && entWordV[i][missWord]) slotBusy = 1'b1;
    end
  end

  // write-back lanes: one per word of the line
  always_comb begin
    wbValid = '0;
    wbDest  = '0;
    for (int k = 0; k < WORDS; k++) begin
      wbData[k*WORD_W +: WORD_W] = fillData[k*WORD_W +: WORD_W];
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (fillHit[i] && entWordV[i][k]) begin
          wbValid[k]               = 1'b1;
          wbDest[k*REG_W +: REG_W] = entDest[i][k];
        end
      end
    end
  end

  always_comb begin
    fullSet = '0;
    fullClr = '0;
    for (int k = 0; k < WORDS; k++)
      if (wbValid[k]) fullSet[wbDest[k*REG_W +: REG_W]] = 1'b1;
    if (strobes.allocEn || strobes.mergeEn) fullClr[missDest] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullQ <= '1;
    end else begin
      fullQ <= (fullQ & ~fullClr) | fullSet;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        entLine[i]  <= '0;
        entWordV[i] <= '0;
        for (int k = 0; k < WORDS; k++) entDest[i][k] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (fillHit[i]) begin
          entValid[i] <= 1'b0;
          entWordV[i] <= '0;
        end else if (strobes.allocEn && allocSel[i]) begin
          entValid[i]           <= 1'b1;
          entLine[i]            <= missLine;
          entWordV[i]           <= WORDS'(1) << missWord;
          entDest[i][missWord]  <= missDest;
        end else if (strobes.mergeEn && missHit[i]) begin
          entWordV[i][missWord] <= 1'b1;
          entDest[i][missWord]  <= missDest;
        end
      end
    end
  end
endmodule

// File: rtl/mshr_ctrl.sv
module mshr_ctrl
  import mshr_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int LINE_W      = 10,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   missValid,
  input  logic [LINE_W-1:0]      missLine,
  input  logic                   fillValid,
  input  logic [LINE_W-1:0]      fillLine,
  input  logic [NUM_ENTRIES-1:0] entryValid,
  input  logic [NUM_ENTRIES-1:0] missHit,
  input  logic                   slotBusy,
  input  logic                   destEmpty,
  input  logic                   memReqReady,
  output mshrStrobes_t           strobes,
  output logic [NUM_ENTRIES-1:0] allocSel,
  output logic [IDX_W-1:0]       headIdx,
  output logic                   missStall,
  output logic                   memReqValid
);
  logic             anyHit;
  logic             anyFree;
  logic             refuse;
  logic [IDX_W-1:0] allocIdx;
  logic [IDX_W-1:0] orderQ [NUM_ENTRIES];
  logic [IDX_W-1:0] rdPtr;
  logic [IDX_W-1:0] wrPtr;
  logic [CNT_W-1:0] count;
  logic             reqPop;

  // lowest free entry, one-hot and encoded
  always_comb begin
    allocSel = '0;
    allocIdx = '0;
    anyFree  = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!entryValid[i] && !anyFree) begin
        anyFree     = 1'b1;
        allocSel[i] = 1'b1;
        allocIdx    = IDX_W'(i);
      end
    end
  end

  assign anyHit = |missHit;
  assign refuse = destEmpty
               || (fillValid && (fillLine == missLine))
               || (anyHit ? slotBusy : !anyFree);

  assign missStall       = missValid && refuse;
  assign strobes.allocEn = missValid && !refuse && !anyHit;
  assign strobes.mergeEn = missValid && !refuse && anyHit;
  assign strobes.fillEn  = fillValid;

  assign memReqValid = (count != '0);
  assign headIdx     = orderQ[rdPtr];
  assign reqPop      = memReqValid && memReqReady;

  function automatic logic [IDX_W-1:0] nextPtr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NUM_ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) orderQ[i] <= '0;
    end else begin
      if (strobes.allocEn) begin
        orderQ[wrPtr] <= allocIdx;
        wrPtr         <= nextPtr(wrPtr);
      end
      if (reqPop) rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(strobes.allocEn) - CNT_W'(reqPop);
    end
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int LINE_W      = 10,
  parameter int WORDS       = 4,
  parameter int WORD_W      = 16,
  parameter int REG_W       = 5,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int OFF_W      = $clog2(WORDS),
  localparam int NUM_REGS   = 1 << REG_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    missValid,
  input  logic [LINE_W-1:0]       missLine,
  input  logic [OFF_W-1:0]        missWord,
  input  logic [REG_W-1:0]        missDest,
  output logic                    missStall,
  input  logic [REG_W-1:0]        decSrcA,
  input  logic [REG_W-1:0]        decSrcB,
  output logic                    decHold,
  output logic                    memReqValid,
  output logic [LINE_W-1:0]       memReqLine,
  input  logic                    memReqReady,
  input  logic                    fillValid,
  input  logic [LINE_W-1:0]       fillLine,
  input  logic [WORDS*WORD_W-1:0] fillData,
  output logic [WORDS-1:0]        wbValid,
  output logic [WORDS*REG_W-1:0]  wbDest,
  output logic [WORDS*WORD_W-1:0] wbData,
  output logic [NUM_REGS-1:0]     regFull
);
  mshrStrobes_t           strobes;
  logic [NUM_ENTRIES-1:0] allocSel;
  logic [IDX_W-1:0]       headIdx;
  logic [NUM_ENTRIES-1:0] entryValid;
  logic [NUM_ENTRIES-1:0] missHit;
  logic                   slotBusy;
  logic                   destEmpty;

  mshr_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missLine(missLine),
    .fillValid(fillValid), .fillLine(fillLine),
    .entryValid(entryValid), .missHit(missHit),
    .slotBusy(slotBusy), .destEmpty(destEmpty),
    .memReqReady(memReqReady),
    .strobes(strobes), .allocSel(allocSel), .headIdx(headIdx),
    .missStall(missStall), .memReqValid(memReqValid)
  );

  mshr_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .LINE_W(LINE_W), .WORDS(WORDS),
    .WORD_W(WORD_W), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .allocSel(allocSel), .headIdx(headIdx),
    .missLine(missLine), .missWord(missWord), .missDest(missDest),
    .fillLine(fillLine), .fillData(fillData),
    .decSrcA(decSrcA), .decSrcB(decSrcB),
    .entryValid(entryValid), .missHit(missHit),
    .slotBusy(slotBusy), .destEmpty(destEmpty),
    .headLine(memReqLine), .decHold(decHold),
    .wbValid(wbValid), .wbDest(wbDest), .wbData(wbData),
    .regFull(regFull)
  );
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int LINE_W   = 10,
  parameter int WORDS    = 4,
  parameter int REG_W    = 5,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int NUM_REGS = 1 << REG_W
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   missValid,
  input logic [LINE_W-1:0]      missLine,
  input logic [OFF_W-1:0]       missWord,
  input logic [REG_W-1:0]       missDest,
  input logic                   missStall,
  input logic                   memReqValid,
  input logic [LINE_W-1:0]      memReqLine,
  input logic                   memReqReady,
  input logic                   fillValid,
  input logic [LINE_W-1:0]      fillLine,
  input logic [WORDS-1:0]       wbValid,
  input logic [WORDS*REG_W-1:0] wbDest,
  input logic [NUM_REGS-1:0]    regFull
);
  a_r6_accept_empties: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && !missStall) |=> !regFull[$past(missDest)]);

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqLine)));

  a_r10_pending_dest_refused: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && !regFull[missDest]) |-> missStall);

  a_r11_fill_race_refused: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && fillValid && (fillLine == missLine)) |-> missStall);

  a_r8_no_wb_without_fill: assert property (@(posedge clk) disable iff (!rstN)
    !fillValid |-> (wbValid == '0));

  for (genvar k = 0; k < WORDS; k++) begin : g_lane
    a_r8_wb_sets_full: assert property (@(posedge clk) disable iff (!rstN)
      wbValid[k] |=> regFull[$past(wbDest[k*REG_W +: REG_W])]);
  end
endmodule

bind mshr_file mshr_file_chk #(.LINE_W(LINE_W), .WORDS(WORDS), .REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .missValid(missValid), .missLine(missLine), .missWord(missWord),
  .missDest(missDest), .missStall(missStall),
  .memReqValid(memReqValid), .memReqLine(memReqLine), .memReqReady(memReqReady),
  .fillValid(fillValid), .fillLine(fillLine),
  .wbValid(wbValid), .wbDest(wbDest), .regFull(regFull)
);

// File: tb/mshr_file_tb.sv
module mshr_file_tb;
  localparam int NE = 4, LW = 10, NW = 4, DW = 16, RW = 5, NR = 32;

  logic clk = 0;
  logic rstN = 0;
  logic missValid = 0;
  logic [LW-1:0] missLine = '0;
  logic [1:0] missWord = '0;
  logic [RW-1:0] missDest = '0;
  logic missStall;
  logic [RW-1:0] decSrcA = '0, decSrcB = '0;
  logic decHold;
  logic memReqValid;
  logic [LW-1:0] memReqLine;
  logic memReqReady = 0;
  logic fillValid = 0;
  logic [LW-1:0] fillLine = '0;
  logic [NW*DW-1:0] fillData = '0;
  logic [NW-1:0] wbValid;
  logic [NW*RW-1:0] wbDest;
  logic [NW*DW-1:0] wbData;
  logic [NR-1:0] regFull;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mshr_file u_dut (.*);

  // reference model state
  bit mValid [NE];
  int mLine [NE];
  bit mWV [NE][NW];
  int mDest [NE][NW];
  bit [NR-1:0] mFull;
  int reqQ[$];
  int issued[$];

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int findLine(int ln);
    for (int i = 0; i < NE; i++) if (mValid[i] && mLine[i] == ln) return i;
    return -1;
  endfunction

  // one cycle: inputs already driven at negedge
  task automatic tick(string tag);
    int hit, fh, freeIdx;
    bit refuse, expStall;
    #1;
    hit = findLine(int'(missLine));
    freeIdx = -1;
    for (int i = NE - 1; i >= 0; i--) if (!mValid[i]) freeIdx = i;
    refuse = !mFull[missDest] || (fillValid && fillLine == missLine) ||
             ((hit >= 0) ? mWV[hit][missWord] : (freeIdx < 0));
    expStall = missValid && refuse;
    fh = fillValid ? findLine(int'(fillLine)) : -1;
    chk(tag, "missStall", missStall, expStall);
    chk(tag, "memReqValid", memReqValid, reqQ.size() > 0);
    if (reqQ.size() > 0) chk(tag, "memReqLine", memReqLine, reqQ[0]);
    chk(tag, "decHold", decHold, !mFull[decSrcA] || !mFull[decSrcB]);
    chk(tag, "regFull", regFull, mFull);
    for (int k = 0; k < NW; k++) begin
      bit ev;
      ev = (fh >= 0) && mWV[fh][k];
      chk(tag, $sformatf("wbValid[%0d]", k), wbValid[k], ev);
      if (ev) begin
        chk(tag, $sformatf("wbDest[%0d]", k), wbDest[k*RW +: RW], mDest[fh][k]);
        chk(tag, $sformatf("wbData[%0d]", k), wbData[k*DW +: DW], fillData[k*DW +: DW]);
      end
    end
    @(posedge clk);
    if (reqQ.size() > 0 && memReqReady) issued.push_back(reqQ.pop_front());
    if (fh >= 0) begin
      for (int k = 0; k < NW; k++) if (mWV[fh][k]) begin
        mFull[mDest[fh][k]] = 1'b1;
        mWV[fh][k] = 0;
      end
      mValid[fh] = 0;
      for (int j = 0; j < issued.size(); j++)
        if (issued[j] == int'(fillLine)) begin issued.delete(j); break; end
    end
    if (missValid && !refuse) begin
      if (hit >= 0) begin
        mWV[hit][missWord] = 1;
        mDest[hit][missWord] = missDest;
      end else begin
        mValid[freeIdx] = 1;
        mLine[freeIdx] = missLine;
        for (int k = 0; k < NW; k++) mWV[freeIdx][k] = 0;
        mWV[freeIdx][missWord] = 1;
        mDest[freeIdx][missWord] = missDest;
        reqQ.push_back(int'(missLine));
      end
      mFull[missDest] = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic setMiss(bit v, int ln, int w, int d);
    missValid = v; missLine = LW'(ln); missWord = 2'(w); missDest = RW'(d);
  endtask

  task automatic setFill(bit v, int ln);
    fillValid = v; fillLine = LW'(ln);
    for (int k = 0; k < NW; k++) fillData[k*DW +: DW] = DW'(16'h1000 * (k + 1) + ln);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mFull = '1;
    for (int i = 0; i < NE; i++) mValid[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    tick("R1");                                  // reset state
    setMiss(1, 'h10, 0, 3); tick("R2");          // allocate, request appears
    setMiss(1, 'h10, 2, 5); tick("R3");          // merge, no new request
    setMiss(1, 'h10, 2, 6); tick("R4");          // word already has a waiter
    setMiss(0, 0, 0, 0); tick("R4");             // state unchanged after refusal
    setMiss(1, 'h20, 1, 3); tick("R10");         // dest already pending
    setMiss(0, 0, 0, 0); decSrcA = 3; decSrcB = 7; tick("R7");
    decSrcA = 7; decSrcB = 5; tick("R7");
    decSrcA = 8; decSrcB = 9; tick("R7");
    setMiss(1, 'h20, 1, 10); tick("R2");
    setMiss(1, 'h30, 3, 11); tick("R2");
    setMiss(1, 'h40, 0, 12); tick("R9");
    setMiss(1, 'h50, 0, 13); tick("R5");         // all entries in use
    setMiss(0, 0, 0, 0); tick("R9");             // held while not ready
    memReqReady = 1;
    repeat (4) tick("R9");                       // 0x10,0x20,0x30,0x40 in order
    memReqReady = 0;
    setFill(1, 'h30); setMiss(1, 'h50, 0, 13); tick("R8");  // out-of-order fill
    setFill(0, 0); tick("R8");                   // freed entry now takes 0x50
    setFill(1, 'h77); setMiss(0, 0, 0, 0); tick("R12");
    setFill(0, 0); tick("R12");
    setFill(1, 'h10); setMiss(1, 'h10, 1, 9); tick("R11");
    setFill(0, 0); setMiss(0, 0, 0, 0); tick("R11");
    setFill(1, 'h40); tick("R8");
    setFill(1, 'h20); tick("R8");
    setFill(0, 0); memReqReady = 1; tick("R9");
    // mixed pseudo-random traffic checked against the model
    for (int n = 0; n < 3000; n++) begin
      setMiss($urandom_range(0, 1), 'h100 + $urandom_range(0, 5),
              $urandom_range(0, 3), $urandom_range(1, 31));
      memReqReady = ($urandom_range(0, 2) != 0);
      decSrcA = RW'($urandom_range(0, 31));
      decSrcB = RW'($urandom_range(0, 31));
      if (issued.size() > 0 && $urandom_range(0, 2) == 0)
        setFill(1, issued[$urandom_range(0, issued.size() - 1)]);
      else
        setFill(0, 0);
      tick("R3");
    end
    setMiss(0, 0, 0, 0); setFill(0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule